// File: doc/BRIEF.md
# Indexed Host Port with Interrupt Aggregation

This block is the host-side glue for a card that carries two HDLC channels and one line-interface controller. It decodes a 32-byte I/O window. A few fixed byte offsets hold an identity pair, a control/status byte, a line-select byte and an index byte. The upper sixteen bytes are a shared data window. The index byte chooses which internal target that window reaches.

Interrupt requests from the line controller, from either HDLC channel and from an internal periodic timer are reported as active-low pending bits. A driver that shares the interrupt line reads the status byte. If the three low bits are all ones, the card did not raise the interrupt. The block drives one active-high interrupt output, gated by an enable bit. It holds a reset level toward the internal targets, and it forwards line-select and serial-bus enable settings to the pins.

Top module: `ioidx_hub`

## Requirements
- R1: A read of offset 2 returns bit0 = NOT line-controller request, bit1 = NOT (OR of HDLC requests), bit2 = NOT timer pending, bit4 = the stored test bit, and zero in bits 3 and 7:5. The value 3'b111 in bits 2:0 means nothing is pending.
- R2: A write to offset 2 loads bit0 card reset, bit1 timer disable, bit2 timer clear, bit3 interrupt enable and bit4 test. After reset all of these are clear except timer disable, which is set.
- R3: `card_rst` is high for exactly as long as the card reset bit stays set.
- R4: An enabled timer sets its pending flag after TMR_PERIOD counted clocks, and the flag stays set. While the clear bit is set, both the count and the flag are held at zero.
- R5: While the timer is disabled and not being cleared, it neither counts nor changes its pending flag.
- R6: `irq_out` is a register that, one clock later, equals the interrupt enable AND the OR of all pending sources. Writing 0 to offset 2 drops it.
- R7: Offset 3 stores the line select in bits 3:0 and the serial-bus enable in bit 7. These drive `irq_sel` and `ser_en`, and they read back with bits 6:4 as zero.
- R8: Offset 4 is a readable 8-bit index. Value 0 selects HDLC channel 1 (target 0), value 1 selects HDLC channel 2 (target 1), value 2 selects the controller FIFO (target 2), value 4 selects the controller low bank (target 3) and value 6 selects the controller high bank (target 4). At most one `tgt_cs` bit is ever high.
- R9: An access to offsets 0x10 to 0x1F is forwarded to the selected target with the low four address bits as `tgt_addr`. If no target is mapped, writes reach nothing and reads return 8'hFF.
- R10: Offset 0 reads CLASS_ID and offset 1 reads REV_ID. Offsets 5 to 0x0F read 0, and writes to those offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_addr | input | 5 | Byte offset within the I/O window |
| hst_rd | input | 1 | Read strobe, data returned in the same cycle |
| hst_wr | input | 1 | Write strobe, taken at the clock edge |
| hst_wdata | input | 8 | Write data |
| hst_rdata | output | 8 | Read data |
| lc_irq | input | 1 | Line-controller request, active high |
| hd_irq | input | NCHAN | HDLC channel requests, active high |
| irq_out | output | 1 | Shared interrupt request |
| irq_sel | output | 4 | Selected interrupt line number |
| ser_en | output | 1 | Serial-bus enable for the line controller |
| card_rst | output | 1 | Reset level to internal targets |
| tgt_cs | output | NUM_TGT | One-hot target select |
| tgt_addr | output | 4 | Offset inside the target |
| tgt_rd | output | 1 | Target read strobe |
| tgt_wr | output | 1 | Target write strobe |
| tgt_wdata | output | 8 | Target write data |
| tgt_rdata | input | 8*NUM_TGT | Read data from each target, target k in bits 8k+7:8k |

## Verification
A wrong stored index shows up on the first window access: the wrong `tgt_cs` bit goes high, or a read returns FF where target data was due. A timer that counts while disabled, or keeps its count across a clear, moves the status bit2 edge by whole periods. The bench therefore samples just before and just after the expected edge. A stale enable or pending flag is visible on `irq_out` one clock after the write that should have changed it.

// File: rtl/ioidx_pkg.sv
package ioidx_pkg;
  localparam int NUM_TGT = 5;
  localparam int TW = $clog2(NUM_TGT + 1);

  localparam logic [4:0] OFS_ID0  = 5'h00;
  localparam logic [4:0] OFS_ID1  = 5'h01;
  localparam logic [4:0] OFS_CTRL = 5'h02;
  localparam logic [4:0] OFS_LINE = 5'h03;
  localparam logic [4:0] OFS_IDX  = 5'h04;

  localparam logic [TW-1:0] TGT_NONE = TW'(NUM_TGT);

  // field order follows the bit positions of the control byte
  typedef struct packed {
    logic test;
    logic irq_en;
    logic tmr_clr;
    logic tmr_off;
    logic card_rst;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{test: 1'b0, irq_en: 1'b0, tmr_clr: 1'b0,
                                 tmr_off: 1'b1, card_rst: 1'b0};

  function automatic logic [TW-1:0] idx_to_tgt(input logic [7:0] v);
    case (v)
      8'd0:    return TW'(0);
      8'd1:    return TW'(1);
      8'd2:    return TW'(2);
      8'd4:    return TW'(3);
      8'd6:    return TW'(4);
      default: return TGT_NONE;
    endcase
  endfunction
endpackage

// File: rtl/ioidx_hub_regs.sv
module ioidx_hub_regs
  import ioidx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [4:0] addr,
  input  logic [7:0] wdata,
  output ctrl_t      ctrl_q,
  output logic [3:0] sel_q,
  output logic       ser_q,
  output logic [7:0] idx_q
);
  logic  ctrl_we, line_we, idx_we;
  ctrl_t ctrl_d;
  logic [3:0] sel_d;
  logic       ser_d;
  logic [7:0] idx_d;

  always_comb begin
    ctrl_we = wr_en && (addr == OFS_CTRL);
    line_we = wr_en && (addr == OFS_LINE);
    idx_we  = wr_en && (addr == OFS_IDX);
    ctrl_d  = ctrl_t'(wdata[4:0]);
    sel_d   = wdata[3:0];
    ser_d   = wdata[7];
    idx_d   = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      ser_q <= 1'b0;
    end else if (line_we) begin
      sel_q <= sel_d;
      ser_q <= ser_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_we) begin
      idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/ioidx_hub_timer.sv
module ioidx_hub_timer #(
  parameter int PERIOD = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic off,
  input  logic clr,
  output logic pend_q
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_d;
  logic          tick_en;

  always_comb begin
    tick_en = clr || !off;
    cnt_d   = cnt_q;
    pend_d  = pend_q;
    if (clr) begin
      cnt_d  = '0;
      pend_d = 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_d  = '0;
      pend_d = 1'b1;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (tick_en) begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/ioidx_hub_window.sv
module ioidx_hub_window
  import ioidx_pkg::*;
(
  input  logic                 hst_rd,
  input  logic                 hst_wr,
  input  logic [4:0]           hst_addr,
  input  logic [7:0]           hst_wdata,
  input  logic [7:0]           idx,
  input  logic [NUM_TGT*8-1:0] tgt_rdata,
  output logic [NUM_TGT-1:0]   tgt_cs,
  output logic [3:0]           tgt_addr,
  output logic                 tgt_rd,
  output logic                 tgt_wr,
  output logic [7:0]           tgt_wdata,
  output logic [7:0]           win_rdata
);
  logic          win;
  logic [TW-1:0] pick;

  assign win  = hst_addr[4];
  assign pick = idx_to_tgt(idx);

  for (genvar k = 0; k < NUM_TGT; k++) begin : g_cs
    assign tgt_cs[k] = win && (pick == TW'(k));
  end

  assign tgt_addr  = hst_addr[3:0];
  assign tgt_wdata = hst_wdata;
  assign tgt_rd    = hst_rd && (|tgt_cs);
  assign tgt_wr    = hst_wr && (|tgt_cs);

  always_comb begin
    win_rdata = 8'hFF;
    for (int k = 0; k < NUM_TGT; k++) begin
      if (tgt_cs[k]) win_rdata = tgt_rdata[k*8 +: 8];
    end
  end
endmodule

// File: rtl/ioidx_hub.sv
module ioidx_hub
  import ioidx_pkg::*;
#(
  parameter int         TMR_PERIOD = 4096,
  parameter int         NCHAN      = 2,
  parameter logic [7:0] CLASS_ID   = 8'h02,
  parameter logic [7:0] REV_ID     = 8'h01
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [4:0]           hst_addr,
  input  logic                 hst_rd,
  input  logic                 hst_wr,
  input  logic [7:0]           hst_wdata,
  output logic [7:0]           hst_rdata,
  input  logic                 lc_irq,
  input  logic [NCHAN-1:0]     hd_irq,
  output logic                 irq_out,
  output logic [3:0]           irq_sel,
  output logic                 ser_en,
  output logic                 card_rst,
  output logic [NUM_TGT-1:0]   tgt_cs,
  output logic [3:0]           tgt_addr,
  output logic                 tgt_rd,
  output logic                 tgt_wr,
  output logic [7:0]           tgt_wdata,
  input  logic [NUM_TGT*8-1:0] tgt_rdata
);
  ctrl_t      ctrl_q;
  logic [7:0] idx_q;
  logic [7:0] win_rdata;
  logic [7:0] stat_byte;
  logic       tmr_pend;
  logic       hd_any;
  logic       src_any;
  logic       irq_en, tmr_off, tmr_clr;
  logic       irq_d, irq_q;

  ioidx_hub_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (hst_wr),
    .addr   (hst_addr),
    .wdata  (hst_wdata),
    .ctrl_q (ctrl_q),
    .sel_q  (irq_sel),
    .ser_q  (ser_en),
    .idx_q  (idx_q)
  );

  assign irq_en   = ctrl_q.irq_en;
  assign tmr_off  = ctrl_q.tmr_off;
  assign tmr_clr  = ctrl_q.tmr_clr;
  assign card_rst = ctrl_q.card_rst;

  ioidx_hub_timer #(.PERIOD(TMR_PERIOD)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .off    (tmr_off),
    .clr    (tmr_clr),
    .pend_q (tmr_pend)
  );

  ioidx_hub_window u_win (
    .hst_rd    (hst_rd),
    .hst_wr    (hst_wr),
    .hst_addr  (hst_addr),
    .hst_wdata (hst_wdata),
    .idx       (idx_q),
    .tgt_rdata (tgt_rdata),
    .tgt_cs    (tgt_cs),
    .tgt_addr  (tgt_addr),
    .tgt_rd    (tgt_rd),
    .tgt_wr    (tgt_wr),
    .tgt_wdata (tgt_wdata),
    .win_rdata (win_rdata)
  );

  // pending sources, reported active low
  assign hd_any    = |hd_irq;
  assign src_any   = lc_irq || hd_any || tmr_pend;
  assign stat_byte = {3'b000, ctrl_q.test, 1'b0, ~tmr_pend, ~hd_any, ~lc_irq};

  assign irq_d = irq_en && src_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_out = irq_q;

  always_comb begin
    hst_rdata = 8'h00;
    if (hst_rd) begin
      if (hst_addr[4]) begin
        hst_rdata = win_rdata;
      end else begin
        case (hst_addr)
          OFS_ID0:  hst_rdata = CLASS_ID;
          OFS_ID1:  hst_rdata = REV_ID;
          OFS_CTRL: hst_rdata = stat_byte;
          OFS_LINE: hst_rdata = {ser_en, 3'b000, irq_sel};
          OFS_IDX:  hst_rdata = idx_q;
          default:  hst_rdata = 8'h00;
        endcase
      end
    end
  end
endmodule

// File: rtl/ioidx_hub_chk.sv
module ioidx_hub_chk
  import ioidx_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               irq_out,
  input logic               irq_en,
  input logic               src_any,
  input logic               tmr_off,
  input logic               tmr_clr,
  input logic               tmr_pend,
  input logic [NUM_TGT-1:0] tgt_cs,
  input logic               hst_rd,
  input logic [4:0]         hst_addr,
  input logic [7:0]         hst_rdata
);
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> !irq_out); // R6
  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && src_any) |=> irq_out); // R6
  AST_TMR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_clr |=> !tmr_pend); // R4
  AST_TMR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_off && !tmr_clr) |=> $stable(tmr_pend)); // R5
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_cs)); // R8
  AST_UNMAPPED_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_rd && hst_addr[4] && (tgt_cs == '0)) |-> (hst_rdata == 8'hFF)); // R9
  AST_IDLE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_rd && (hst_addr == OFS_CTRL) && !src_any) |-> (hst_rdata[2:0] == 3'b111)); // R1
endmodule

bind ioidx_hub ioidx_hub_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_out   (irq_out),
  .irq_en    (irq_en),
  .src_any   (src_any),
  .tmr_off   (tmr_off),
  .tmr_clr   (tmr_clr),
  .tmr_pend  (tmr_pend),
  .tgt_cs    (tgt_cs),
  .hst_rd    (hst_rd),
  .hst_addr  (hst_addr),
  .hst_rdata (hst_rdata)
);

// File: tb/sim_ioidx_hub.sv
module sim_ioidx_hub;
  localparam time TCLK = 10ns;
  localparam int  P    = 16;
  localparam int  NT   = ioidx_pkg::NUM_TGT;

  logic            clk, rst_n;
  logic [4:0]      hst_addr;
  logic            hst_rd, hst_wr;
  logic [7:0]      hst_wdata, hst_rdata;
  logic            lc_irq;
  logic [1:0]      hd_irq;
  logic            irq_out, ser_en, card_rst;
  logic [3:0]      irq_sel, tgt_addr;
  logic [NT-1:0]   tgt_cs;
  logic            tgt_rd, tgt_wr;
  logic [7:0]      tgt_wdata;
  logic [NT*8-1:0] tgt_rdata;

  ioidx_hub #(.TMR_PERIOD(P), .NCHAN(2), .CLASS_ID(8'hC3), .REV_ID(8'h07)) u0 (
    .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_rd(hst_rd), .hst_wr(hst_wr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .lc_irq(lc_irq), .hd_irq(hd_irq),
    .irq_out(irq_out), .irq_sel(irq_sel), .ser_en(ser_en), .card_rst(card_rst),
    .tgt_cs(tgt_cs), .tgt_addr(tgt_addr), .tgt_rd(tgt_rd), .tgt_wr(tgt_wr),
    .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata)
  );

  // target models: target k answers {k+1, offset}
  for (genvar k = 0; k < NT; k++) begin : g_tgt
    assign tgt_rdata[k*8 +: 8] = {4'(k + 1), tgt_addr};
  end

  initial clk = 1'b0;
  always #(TCLK / 2) clk = ~clk;

  typedef struct {
    logic [7:0] exp;
    logic [4:0] a;
    string      req;
  } exp_t;
  exp_t sbq[$];

  int n_chk = 0;
  int n_bad = 0;
  int wr_cnt = 0;
  int last_k = -1;
  logic [3:0] last_a;
  logic [7:0] last_d;

  // monitor: compare each read against the scoreboard
  always @(negedge clk) begin : mon
    exp_t e;
    if (hst_rd) begin
      n_chk++;
      if (sbq.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard empty: got %h exp none", hst_rdata);
      end else begin
        e = sbq.pop_front();
        if (hst_rdata !== e.exp) begin
          n_bad++;
          $display("FAIL %s read @%h: got %h exp %h", e.req, e.a, hst_rdata, e.exp);
        end
      end
    end
  end

  // capture target writes
  always @(posedge clk) begin
    if (tgt_wr) begin
      wr_cnt++;
      for (int k = 0; k < NT; k++) if (tgt_cs[k]) last_k = k;
      last_a = tgt_addr;
      last_d = tgt_wdata;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
    @(posedge clk); #1;
    hst_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] exp, input string req);
    exp_t e;
    @(posedge clk); #1;
    e.exp = exp; e.a = a; e.req = req;
    sbq.push_back(e);
    hst_addr = a; hst_rd = 1'b1;
    @(posedge clk); #1;
    hst_rd = 1'b0;
  endtask

  task automatic chk(input int act, input int exp, input string req, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d exp %0d", req, what, act, exp);
    end
  endtask

  task automatic wrap_up;
    if (sbq.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL scoreboard: got %0d pending exp 0", sbq.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(TCLK * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    wrap_up();
  end

  initial begin
    int c;
    logic [7:0] idxs [5] = '{8'd0, 8'd1, 8'd2, 8'd4, 8'd6};
    rst_n = 1'b0; hst_addr = '0; hst_rd = 1'b0; hst_wr = 1'b0; hst_wdata = '0;
    lc_irq = 1'b0; hd_irq = 2'b00;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // reset state
    chk(irq_out, 0, "R6", "irq after reset");
    chk(card_rst, 0, "R3", "card_rst after reset");
    tick(2 * P);
    rd(5'h02, 8'h07, "R2");     // timer disabled from reset
    rd(5'h03, 8'h00, "R7");
    rd(5'h04, 8'h00, "R8");

    // identity and unused offsets
    rd(5'h00, 8'hC3, "R10");
    rd(5'h01, 8'h07, "R10");
    rd(5'h05, 8'h00, "R10");
    wr(5'h05, 8'hFF);
    rd(5'h05, 8'h00, "R10");
    rd(5'h0F, 8'h00, "R10");
    rd(5'h02, 8'h07, "R10");

    // active-low source bits
    lc_irq = 1'b1;
    rd(5'h02, 8'h06, "R1");
    lc_irq = 1'b0; hd_irq = 2'b10;
    rd(5'h02, 8'h05, "R1");
    lc_irq = 1'b1; hd_irq = 2'b01;
    rd(5'h02, 8'h04, "R1");
    lc_irq = 1'b0; hd_irq = 2'b00;

    // card reset level
    wr(5'h02, 8'h03);
    chk(card_rst, 1, "R3", "card_rst set");
    tick(5);
    chk(card_rst, 1, "R3", "card_rst held");
    wr(5'h02, 8'h02);
    chk(card_rst, 0, "R3", "card_rst released");

    // test bit
    wr(5'h02, 8'h12);
    rd(5'h02, 8'h17, "R1");
    wr(5'h02, 8'h02);

    // timer period
    wr(5'h02, 8'h04);
    wr(5'h02, 8'h00);
    tick(P - 6);
    rd(5'h02, 8'h07, "R4");
    tick(8);
    rd(5'h02, 8'h03, "R4");
    tick(2 * P);
    rd(5'h02, 8'h03, "R4");
    chk(irq_out, 0, "R6", "irq masked");
    wr(5'h02, 8'h08);
    tick(1);
    chk(irq_out, 1, "R6", "irq from timer");
    wr(5'h02, 8'h0C);
    tick(2);
    chk(irq_out, 0, "R4", "irq after timer clear");
    rd(5'h02, 8'h07, "R4");

    // disabled timer holds
    wr(5'h02, 8'h02);
    tick(3 * P);
    rd(5'h02, 8'h07, "R5");
    wr(5'h02, 8'h00);
    tick(P + 4);
    rd(5'h02, 8'h03, "R5");
    wr(5'h02, 8'h04);
    rd(5'h02, 8'h07, "R4");
    wr(5'h02, 8'h02);

    // line-controller interrupt and release write
    lc_irq = 1'b1;
    wr(5'h02, 8'h0A);
    tick(1);
    chk(irq_out, 1, "R6", "irq from line controller");
    rd(5'h02, 8'h06, "R6");
    wr(5'h02, 8'h00);
    tick(1);
    chk(irq_out, 0, "R6", "irq after release write");
    lc_irq = 1'b0;
    wr(5'h02, 8'h06);

    // line select register
    wr(5'h03, 8'h8A);
    rd(5'h03, 8'h8A, "R7");
    chk(irq_sel, 10, "R7", "irq_sel");
    chk(ser_en, 1, "R7", "ser_en");
    wr(5'h03, 8'h75);
    rd(5'h03, 8'h05, "R7");
    chk(ser_en, 0, "R7", "ser_en cleared");

    // index mapping and window forwarding
    for (int i = 0; i < NT; i++) begin
      logic [3:0] a4;
      a4 = 4'(i + 3);
      wr(5'h04, idxs[i]);
      rd(5'h04, idxs[i], "R8");
      rd({1'b1, a4}, {4'(i + 1), a4}, "R9");
      c = wr_cnt;
      wr({1'b1, a4}, 8'h5A ^ 8'(i));
      chk(wr_cnt, c + 1, "R9", "target write count");
      chk(last_k, i, "R8", "target picked");
      chk(last_a, a4, "R9", "target offset");
      chk(last_d, 8'h5A ^ 8'(i), "R9", "target data");
    end

    // unmapped index values
    wr(5'h04, 8'd3);
    rd(5'h15, 8'hFF, "R9");
    c = wr_cnt;
    wr(5'h15, 8'h33);
    chk(wr_cnt, c, "R9", "no write on unmapped index");
    wr(5'h04, 8'h86);
    rd(5'h1E, 8'hFF, "R9");
    wr(5'h1E, 8'h44);
    chk(wr_cnt, c, "R9", "no write on high unmapped index");

    tick(2);
    wrap_up();
  end
endmodule